// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block computes the effective address of a single memory reference. Each valid request carries a 3-bit mode code, a pointer register number, an 8-bit scale/index/base selector, an immediate field, the current program counter and an operand-size flag. The block drives two register-file read addresses and takes back the two values combinationally. It then forms the address and registers it. The auto-modifying modes also return an updated pointer value and a write enable, so the surrounding pipeline can write that value back to the register file.

Six modes are implemented:

- pointer through a register;
- register plus a sign-extended 16-bit offset;
- base plus a scaled index plus a displacement;
- a branch target relative to the program counter;
- post-increment;
- pre-decrement.

The two remaining mode codes are reported as illegal. All arithmetic wraps modulo 2^32. The register file, memory and instruction fetch are outside the block.

Top module: `ea_gen`

## Requirements
- R1: While reset is asserted and until the first valid request, `out_valid`, `wb_en` and `illegal` are 0 and `ea` is 0.
- R2: The outputs for a request sampled with `in_valid`=1 appear on the next clock edge with `out_valid`=1. After a cycle with `in_valid`=0, `out_valid`, `wb_en` and `illegal` are 0, and `ea`, `wb_data` and `wb_addr` keep their last values.
- R3: For mode code 0 (pointer), `ea` is the value of register `ptr` and `wb_en` is 0.
- R4: For mode code 1 (register plus offset), `ea` = R[`ptr`] + sign-extended `imm[15:0]`, wrapping modulo 2^32. A negative offset gives an address below the base, and `wb_en` is 0.
- R5: For mode code 2 (scaled), `sib[7:6]` gives the scale (00 is ×1, 01 is ×2, 10 is ×4, 11 is ×8), `sib[5:3]` the index register and `sib[2:0]` the base register. `ea` = R[base] + (R[index] shifted left by the scale) + displacement, and `wb_en` is 0.
- R6: In mode code 2, `disp_long`=1 uses the full 32-bit `imm` as the displacement. `disp_long`=0 sign-extends `imm[7:0]`, and `imm[31:8]` has no effect on `ea`.
- R7: For mode code 3 (PC-relative), `ea` = `pc` + 4 + (sign-extended `imm[15:0]` shifted left by 2), and `wb_en` is 0.
- R8: For mode code 4 (post-increment), `ea` is the current value of R[`ptr`]. `wb_en` is 1, `wb_addr` is `ptr` and `wb_data` is R[`ptr`] plus the step.
- R9: For mode code 5 (pre-decrement), `ea` and `wb_data` are both R[`ptr`] minus the step. `wb_en` is 1 and `wb_addr` is `ptr`.
- R10: The step is 1 when `size_word`=0 (byte) and 2 when `size_word`=1 (word). It wraps modulo 2^32.
- R11: Mode codes 6 and 7 give `illegal`=1, `wb_en`=0 and `ea`=0. `illegal` is 0 for every other code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request valid |
| mode | input | 3 | Mode code |
| ptr | input | 3 | Pointer/base register number for non-scaled modes |
| sib | input | 8 | Scale/index/base selector |
| imm | input | 32 | Offset or displacement field |
| disp_long | input | 1 | Scaled mode: 1 selects the 32-bit displacement, 0 the 8-bit one |
| pc | input | 32 | Address of the current instruction |
| size_word | input | 1 | Operand size: 0 byte, 1 word |
| rd_addr0 | output | 3 | Read port 0 register number (base/pointer) |
| rd_data0 | input | 32 | Read port 0 data |
| rd_addr1 | output | 3 | Read port 1 register number (index) |
| rd_data1 | input | 32 | Read port 1 data |
| out_valid | output | 1 | Result valid |
| ea | output | 32 | Effective address |
| illegal | output | 1 | Unused mode code was requested |
| wb_en | output | 1 | Pointer writeback enable |
| wb_addr | output | 3 | Pointer writeback register |
| wb_data | output | 32 | Pointer writeback value |

## Verification
The bench builds the block with its default parameters: 32-bit data, eight registers, a 4-byte instruction and a 16-bit offset field. With these values the top of the offset range, the sign bit of the 8-bit displacement and wrap-around at 2^32 can all be reached by directed values. Back-to-back post-increment and pre-decrement requests walk one pointer through its own writebacks, and idle cycles between requests show that the outputs are held. A pseudo-random tail mixes every mode code, including the two illegal ones.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
  typedef enum logic [2:0] {
    MD_PTR     = 3'd0,
    MD_BOFS    = 3'd1,
    MD_SCALED  = 3'd2,
    MD_PCREL   = 3'd3,
    MD_POSTINC = 3'd4,
    MD_PREDEC  = 3'd5
  } ea_mode_e;

  localparam int unsigned MODE_W  = 3;
  localparam int unsigned SCALE_W = 2;
endpackage

// File: rtl/ea_rst_sync.sv
module ea_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ea_sib_decode.sv
module ea_sib_decode
  import ea_gen_pkg::*;
#(
  parameter int unsigned RA_W = 3
) (
  input  logic [SCALE_W+2*RA_W-1:0] sib_i,
  output logic [RA_W-1:0]           base_o,
  output logic [RA_W-1:0]           index_o,
  output logic [SCALE_W-1:0]        scale_o
);
  localparam int unsigned IDX_LSB = RA_W;
  localparam int unsigned SCL_LSB = 2 * RA_W;

  assign base_o  = sib_i[RA_W-1:0];
  assign index_o = sib_i[IDX_LSB +: RA_W];
  assign scale_o = sib_i[SCL_LSB +: SCALE_W];
endmodule

// File: rtl/ea_port_select.sv
module ea_port_select
  import ea_gen_pkg::*;
#(
  parameter int unsigned RA_W = 3
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [RA_W-1:0]   ptr_i,
  input  logic [RA_W-1:0]   sib_base_i,
  input  logic [RA_W-1:0]   sib_index_i,
  output logic [RA_W-1:0]   rd_addr0_o,
  output logic [RA_W-1:0]   rd_addr1_o
);
  always_comb begin
    rd_addr0_o = ptr_i;
    rd_addr1_o = '0;
    if (ea_mode_e'(mode_i) == MD_SCALED) begin
      rd_addr0_o = sib_base_i;
      rd_addr1_o = sib_index_i;
    end
  end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_gen_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned OFS_W      = 16,
  parameter int unsigned SDISP_W    = 8,
  parameter int unsigned INSN_BYTES = 4,
  parameter int unsigned PC_SHIFT   = 2
) (
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [XLEN-1:0]    base_i,
  input  logic [XLEN-1:0]    index_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [XLEN-1:0]    imm_i,
  input  logic               disp_long_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               size_word_i,
  output logic [XLEN-1:0]    ea_o,
  output logic [XLEN-1:0]    wb_data_o,
  output logic               wb_en_o,
  output logic               illegal_o
);
  localparam int unsigned OFS_PAD   = XLEN - OFS_W;
  localparam int unsigned SDISP_PAD = XLEN - SDISP_W;
  localparam logic [XLEN-1:0] NEXT_PC_DELTA = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] STEP_BYTE     = XLEN'(1);
  localparam logic [XLEN-1:0] STEP_WORD     = XLEN'(2);

  logic [XLEN-1:0] ofs_sx;
  logic [XLEN-1:0] sdisp_sx;
  logic [XLEN-1:0] disp_sel;
  logic [XLEN-1:0] index_scaled;
  logic [XLEN-1:0] step;
  logic [XLEN-1:0] pc_next;
  logic [XLEN-1:0] pc_ofs;

  assign ofs_sx       = {{OFS_PAD{imm_i[OFS_W-1]}}, imm_i[OFS_W-1:0]};
  assign sdisp_sx     = {{SDISP_PAD{imm_i[SDISP_W-1]}}, imm_i[SDISP_W-1:0]};
  assign disp_sel     = disp_long_i ? imm_i : sdisp_sx;
  assign index_scaled = index_i << scale_i;
  assign step         = size_word_i ? STEP_WORD : STEP_BYTE;
  assign pc_next      = pc_i + NEXT_PC_DELTA;
  assign pc_ofs       = ofs_sx << PC_SHIFT;

  always_comb begin
    ea_o      = '0;
    wb_data_o = '0;
    wb_en_o   = 1'b0;
    illegal_o = 1'b0;
    case (ea_mode_e'(mode_i))
      MD_PTR: begin
        ea_o = base_i;
      end
      MD_BOFS: begin
        ea_o = base_i + ofs_sx;
      end
      MD_SCALED: begin
        ea_o = base_i + index_scaled + disp_sel;
      end
      MD_PCREL: begin
        ea_o = pc_next + pc_ofs;
      end
      MD_POSTINC: begin
        ea_o      = base_i;
        wb_data_o = base_i + step;
        wb_en_o   = 1'b1;
      end
      MD_PREDEC: begin
        ea_o      = base_i - step;
        wb_data_o = base_i - step;
        wb_en_o   = 1'b1;
      end
      default: begin
        illegal_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned NREG       = 8,
  parameter int unsigned OFS_W      = 16,
  parameter int unsigned SDISP_W    = 8,
  parameter int unsigned INSN_BYTES = 4,
  parameter int unsigned PC_SHIFT   = 2,
  localparam int unsigned RA_W      = $clog2(NREG),
  localparam int unsigned SIB_W     = SCALE_W + 2 * RA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MODE_W-1:0] mode,
  input  logic [RA_W-1:0]   ptr,
  input  logic [SIB_W-1:0]  sib,
  input  logic [XLEN-1:0]   imm,
  input  logic              disp_long,
  input  logic [XLEN-1:0]   pc,
  input  logic              size_word,
  output logic [RA_W-1:0]   rd_addr0,
  input  logic [XLEN-1:0]   rd_data0,
  output logic [RA_W-1:0]   rd_addr1,
  input  logic [XLEN-1:0]   rd_data1,
  output logic              out_valid,
  output logic [XLEN-1:0]   ea,
  output logic              illegal,
  output logic              wb_en,
  output logic [RA_W-1:0]   wb_addr,
  output logic [XLEN-1:0]   wb_data
);
  logic               rst_sync_n;
  logic [RA_W-1:0]    sib_base;
  logic [RA_W-1:0]    sib_index;
  logic [SCALE_W-1:0] sib_scale;
  logic [XLEN-1:0]    calc_ea;
  logic [XLEN-1:0]    calc_wb_data;
  logic               calc_wb_en;
  logic               calc_illegal;

  logic               vld_d,  vld_q;
  logic               ill_d,  ill_q;
  logic               wbe_d,  wbe_q;
  logic               load_en;
  logic [XLEN-1:0]    ea_d,   ea_q;
  logic [XLEN-1:0]    wbd_d,  wbd_q;
  logic [RA_W-1:0]    wba_d,  wba_q;

  ea_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ea_sib_decode #(.RA_W(RA_W)) u_sib (
    .sib_i   (sib),
    .base_o  (sib_base),
    .index_o (sib_index),
    .scale_o (sib_scale)
  );

  ea_port_select #(.RA_W(RA_W)) u_ports (
    .mode_i      (mode),
    .ptr_i       (ptr),
    .sib_base_i  (sib_base),
    .sib_index_i (sib_index),
    .rd_addr0_o  (rd_addr0),
    .rd_addr1_o  (rd_addr1)
  );

  ea_calc #(
    .XLEN       (XLEN),
    .OFS_W      (OFS_W),
    .SDISP_W    (SDISP_W),
    .INSN_BYTES (INSN_BYTES),
    .PC_SHIFT   (PC_SHIFT)
  ) u_calc (
    .mode_i      (mode),
    .base_i      (rd_data0),
    .index_i     (rd_data1),
    .scale_i     (sib_scale),
    .imm_i       (imm),
    .disp_long_i (disp_long),
    .pc_i        (pc),
    .size_word_i (size_word),
    .ea_o        (calc_ea),
    .wb_data_o   (calc_wb_data),
    .wb_en_o     (calc_wb_en),
    .illegal_o   (calc_illegal)
  );

  always_comb begin
    load_en = in_valid;
    vld_d   = in_valid;
    ill_d   = in_valid & calc_illegal;
    wbe_d   = in_valid & calc_wb_en;
    ea_d    = calc_ea;
    wbd_d   = calc_wb_data;
    wba_d   = ptr;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      ill_q <= 1'b0;
      wbe_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      ill_q <= ill_d;
      wbe_q <= wbe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ea_q  <= '0;
      wbd_q <= '0;
      wba_q <= '0;
    end else if (load_en) begin
      ea_q  <= ea_d;
      wbd_q <= wbd_d;
      wba_q <= wba_d;
    end
  end

  assign out_valid = vld_q;
  assign illegal   = ill_q;
  assign wb_en     = wbe_q;
  assign ea        = ea_q;
  assign wb_data   = wbd_q;
  assign wb_addr   = wba_q;
endmodule

// File: rtl/ea_gen_checker.sv
module ea_gen_checker #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RA_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        mode,
  input logic [RA_W-1:0]   ptr,
  input logic [2*RA_W+1:0] sib,
  input logic              size_word,
  input logic [RA_W-1:0]   rd_addr0,
  input logic [RA_W-1:0]   rd_addr1,
  input logic [XLEN-1:0]   rd_data0,
  input logic              out_valid,
  input logic [XLEN-1:0]   ea,
  input logic              illegal,
  input logic              wb_en,
  input logic [RA_W-1:0]   wb_addr,
  input logic [XLEN-1:0]   wb_data
);
  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !wb_en && !illegal && $stable(ea))); // R2
  AST_PTR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd0) |=> (ea == $past(rd_data0) && !wb_en)); // R3
  AST_SIB_PORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd2) |-> (rd_addr0 == sib[RA_W-1:0] && rd_addr1 == sib[2*RA_W-1:RA_W])); // R5
  AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd4) |=> (wb_en && (wb_data - ea) == ($past(size_word) ? XLEN'(2) : XLEN'(1)))); // R8
  AST_PREDEC_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd5) |=> (wb_en && wb_data == ea && wb_addr == $past(ptr))); // R9
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wb_en && ea == '0 && out_valid)); // R11
  AST_WB_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (out_valid && !illegal)); // R8
endmodule

bind ea_gen ea_gen_checker #(.XLEN(XLEN), .RA_W(RA_W)) u_ea_gen_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .mode      (mode),
  .ptr       (ptr),
  .sib       (sib),
  .size_word (size_word),
  .rd_addr0  (rd_addr0),
  .rd_addr1  (rd_addr1),
  .rd_data0  (rd_data0),
  .out_valid (out_valid),
  .ea        (ea),
  .illegal   (illegal),
  .wb_en     (wb_en),
  .wb_addr   (wb_addr),
  .wb_data   (wb_data)
);

// File: tb/test_ea_gen.sv
module test_ea_gen;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  mode;
  logic [2:0]  ptr;
  logic [7:0]  sib;
  logic [31:0] imm;
  logic        disp_long;
  logic [31:0] pc;
  logic        size_word;
  logic [2:0]  rd_addr0, rd_addr1;
  logic [31:0] rd_data0, rd_data1;
  logic        out_valid, illegal, wb_en;
  logic [31:0] ea, wb_data;
  logic [2:0]  wb_addr;

  logic [31:0] rf [8];
  assign rd_data0 = rf[rd_addr0];
  assign rd_data1 = rf[rd_addr1];

  ea_gen i_ea_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .ptr(ptr),
    .sib(sib), .imm(imm), .disp_long(disp_long), .pc(pc), .size_word(size_word),
    .rd_addr0(rd_addr0), .rd_data0(rd_data0), .rd_addr1(rd_addr1), .rd_data1(rd_data1),
    .out_valid(out_valid), .ea(ea), .illegal(illegal), .wb_en(wb_en),
    .wb_addr(wb_addr), .wb_data(wb_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    bit        v;
    bit [2:0]  md;
    bit        dl;
    bit [31:0] ea;
    bit        ill;
    bit        wbe;
    bit [2:0]  wba;
    bit [31:0] wbd;
  } exp_t;

  exp_t        q[$];
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;
  bit [31:0]   last_ea = 0;
  bit [31:0]   last_wbd = 0;
  bit [2:0]    last_wba = 0;

  task automatic chk(string tag, bit [31:0] act, bit [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic string ea_tag(bit [2:0] md, bit dl);
    case (md)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return dl ? "R5" : "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      3'd5: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic exp_t model(bit v, bit [2:0] md, bit [2:0] p, bit [7:0] s,
                                 bit [31:0] im, bit dl, bit [31:0] pcv, bit sz);
    exp_t e;
    bit [31:0] stp, ofs, dsp;
    e.v = v; e.md = md; e.dl = dl; e.ea = 0; e.ill = 0; e.wbe = 0; e.wba = p; e.wbd = 0;
    stp = sz ? 32'd2 : 32'd1;
    ofs = {{16{im[15]}}, im[15:0]};
    case (md)
      3'd0: e.ea = rf[p];
      3'd1: e.ea = rf[p] + ofs;
      3'd2: begin
        dsp  = dl ? im : {{24{im[7]}}, im[7:0]};
        e.ea = rf[s[2:0]] + (rf[s[5:3]] << s[7:6]) + dsp;
      end
      3'd3: e.ea = pcv + 32'd4 + (ofs << 2);
      3'd4: begin e.ea = rf[p]; e.wbe = 1; e.wbd = rf[p] + stp; end
      3'd5: begin e.ea = rf[p] - stp; e.wbe = 1; e.wbd = e.ea; end
      default: e.ill = 1;
    endcase
    return e;
  endfunction

  task automatic issue(bit v, bit [2:0] md, bit [2:0] p, bit [7:0] s,
                       bit [31:0] im, bit dl, bit [31:0] pcv, bit sz);
    exp_t e;
    in_valid = v; mode = md; ptr = p; sib = s; imm = im; disp_long = dl; pc = pcv; size_word = sz;
    q.push_back(model(v, md, p, s, im, dl, pcv, sz));
    @(negedge clk);
    e = q.pop_front();
    if (e.v) begin
      chk("R2 out_valid", 32'(out_valid), 32'd1);
      chk(ea_tag(e.md, e.dl), ea, e.ea);
      chk("R11 illegal", 32'(illegal), 32'(e.ill));
      chk(e.wbe ? "R8 wb_en" : "R3 wb_en", 32'(wb_en), 32'(e.wbe));
      if (e.wbe) begin
        chk("R10 wb_data", wb_data, e.wbd);
        chk("R9 wb_addr", 32'(wb_addr), 32'(e.wba));
        rf[e.wba] = e.wbd;
        last_wbd = e.wbd; last_wba = e.wba;
      end
      last_ea = e.ea;
    end else begin
      chk("R2 idle out_valid", 32'(out_valid), 32'd0);
      chk("R2 idle wb_en", 32'(wb_en), 32'd0);
      chk("R2 hold ea", ea, last_ea);
    end
  endtask

  task automatic idle();
    issue(0, 3'd0, 3'd0, 8'd0, 32'd0, 0, 32'd0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [31:0] lf;
    rst_n = 0; in_valid = 0; mode = 0; ptr = 0; sib = 0; imm = 0;
    disp_long = 0; pc = 0; size_word = 0;
    rf[0] = 32'h0000_1000; rf[1] = 32'h0000_0010; rf[2] = 32'h8000_0000; rf[3] = 32'h0000_0003;
    rf[4] = 32'hFFFF_FFFF; rf[5] = 32'h0000_0000; rf[6] = 32'h1234_5678; rf[7] = 32'h0000_0100;
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", 32'(out_valid), 32'd0);
    chk("R1 reset wb_en", 32'(wb_en), 32'd0);
    chk("R1 reset illegal", 32'(illegal), 32'd0);
    chk("R1 reset ea", ea, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 after release out_valid", 32'(out_valid), 32'd0);

    // R3 pointer
    issue(1, 3'd0, 3'd6, 8'hFF, 32'hFFFF_FFFF, 1, 32'h40, 1);
    issue(1, 3'd0, 3'd0, 8'h00, 32'h0, 0, 32'h0, 0);
    // R4 register plus offset: positive, negative, wrap
    issue(1, 3'd1, 3'd0, 8'h00, 32'h0000_7FFF, 0, 32'h0, 0);
    issue(1, 3'd1, 3'd0, 8'h00, 32'hABCD_FFF0, 0, 32'h0, 0);
    issue(1, 3'd1, 3'd1, 8'h00, 32'h0000_FFE0, 0, 32'h0, 0);
    issue(1, 3'd1, 3'd2, 8'h00, 32'h0000_8000, 0, 32'h0, 0);
    // R5 all scales, long displacement
    for (int sc = 0; sc < 4; sc++)
      issue(1, 3'd2, 3'd0, {2'(sc), 3'd3, 3'd7}, 32'h0001_0000, 1, 32'h0, 0);
    issue(1, 3'd2, 3'd0, {2'd3, 3'd4, 3'd4}, 32'h0000_0008, 1, 32'h0, 0);
    issue(1, 3'd2, 3'd0, {2'd1, 3'd6, 3'd2}, 32'hFFFF_FFFC, 1, 32'h0, 0);
    // R6 short displacement, upper imm bits ignored
    issue(1, 3'd2, 3'd0, {2'd2, 3'd3, 3'd0}, 32'h5A5A_5AF0, 0, 32'h0, 0);
    issue(1, 3'd2, 3'd0, {2'd2, 3'd3, 3'd0}, 32'hFFFF_FF7F, 0, 32'h0, 0);
    issue(1, 3'd2, 3'd0, {2'd0, 3'd1, 3'd1}, 32'h0000_0080, 0, 32'h0, 0);
    // R7 PC-relative
    issue(1, 3'd3, 3'd0, 8'h00, 32'h0000_0010, 0, 32'h0000_2000, 0);
    issue(1, 3'd3, 3'd0, 8'h00, 32'h0000_FFFF, 0, 32'h0000_2000, 0);
    issue(1, 3'd3, 3'd0, 8'h00, 32'h0000_8000, 0, 32'h0001_0000, 0);
    // R8 / R10 post-increment walk, byte then word, and wrap
    issue(1, 3'd4, 3'd7, 8'h00, 32'h0, 0, 32'h0, 0);
    issue(1, 3'd4, 3'd7, 8'h00, 32'h0, 0, 32'h0, 0);
    issue(1, 3'd4, 3'd7, 8'h00, 32'h0, 0, 32'h0, 1);
    issue(1, 3'd0, 3'd7, 8'h00, 32'h0, 0, 32'h0, 0);
    issue(1, 3'd4, 3'd4, 8'h00, 32'h0, 0, 32'h0, 0);
    // R9 / R10 pre-decrement, word then byte, wrap below zero
    issue(1, 3'd5, 3'd7, 8'h00, 32'h0, 0, 32'h0, 1);
    issue(1, 3'd5, 3'd7, 8'h00, 32'h0, 0, 32'h0, 0);
    issue(1, 3'd5, 3'd4, 8'h00, 32'h0, 0, 32'h0, 1);
    // R2 idle hold
    idle();
    chk("R2 hold wb_data", wb_data, last_wbd);
    chk("R2 hold wb_addr", 32'(wb_addr), 32'(last_wba));
    idle();
    // R11 illegal codes, pointer untouched afterwards
    issue(1, 3'd6, 3'd7, 8'h00, 32'h0, 0, 32'h0, 1);
    issue(1, 3'd7, 3'd7, 8'h00, 32'h0, 0, 32'h0, 1);
    issue(1, 3'd0, 3'd7, 8'h00, 32'h0, 0, 32'h0, 0);
    idle();
    // mixed pseudo-random traffic
    lf = 32'hACE1_2345;
    for (int n = 0; n < 300; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      issue(lf[29] | lf[28], lf[2:0], lf[5:3], lf[13:6], {lf[15:0], lf[31:16]},
            lf[20], {lf[23:0], 8'h00}, lf[27]);
    end
    idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule